// File: doc/BRIEF.md
# Interrupt Line Port Selector

This block routes GPIO pin levels onto a set of external-interrupt lines. The pins arrive as a flat vector made of several ports of equal width. Pin `k` of every port competes for interrupt line `k`. A small select field for each line picks which port wins that line. The routing is purely combinational, so a level change on the chosen pin shows up on the line in the same cycle. Edge detection and pending logic sit downstream and are not part of this block.

The select fields are packed four to a 32-bit register, and software programs them over a word-addressed register bus. Two legacy configuration registers sit on the same bus. They accept writes, keep nothing and always read as zero. A compensation-control register is a plain 32-bit storage word. Any other offset in the 1 KiB window reads as zero and ignores writes. Such an access also raises a one-cycle error flag.

Top module: `irq_line_router`

## Requirements
- R1: Line `k` carries pin input `s*16 + k`, where `s` is the line's 4-bit select field, whenever `s` is below 9. The path is combinational.
- R2: A line whose select field holds 9 to 15 is driven low, whatever the pin levels are.
- R3: The select register for lines `4j..4j+3` sits at byte offset `0x08 + 4*j` (j = 0..3). Line `k` uses bits `[(k%4)*4 +: 4]` of register `k/4`. A write keeps only data bits `[15:0]`, and bits `[31:16]` read back as zero.
- R4: Offsets `0x00` and `0x04` accept writes but store nothing, and they always read `0x00000000`.
- R5: Offset `0x20` stores all 32 written bits and returns them on read.
- R6: After reset every register reads `0x00000000`, so every line follows the pin of the same number on port 0.
- R7: Every other offset reads `0x00000000` and a write to it changes no register. This includes `0x18`, `0x1C`, offsets up to `0x3FC`, and any offset with bits `[1:0]` not equal to zero.
- R8: `err_o` is high for exactly the one cycle after a bus access (read or write) to an offset covered by R7, and low at all other times.
- R9: Read data appears on `bus_rdata` one cycle after a read access and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 10 | Byte offset within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| err_o | output | 1 | One-cycle flag for an access to an unmapped offset |
| pin_i | input | 144 | Pin levels, index = port*16 + pin |
| line_o | output | 16 | Interrupt line levels |

## Verification
The checker watches the bus side on every cycle. It checks that the error flag matches the previous cycle's access to an unmapped offset. It checks that reads of the legacy words and of unmapped offsets return zero, and that a select register never shows upper bits. It also checks that no line rises while every pin is low. Only the bench scenarios can show the routing itself. Those scenarios cover which port each field value picks, the low output for out-of-range fields, and whether a stray write left the stored selections untouched.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
   typedef enum logic [2:0] {
      RK_NONE  = 3'd0,
      RK_REMAP = 3'd1,
      RK_MODE  = 3'd2,
      RK_SEL   = 3'd3,
      RK_COMP  = 3'd4
   } reg_kind_e;
endpackage

// File: rtl/irq_router_dec.sv
module irq_router_dec
   import irq_router_pkg::*;
#(
   parameter int unsigned ADDR_W = 10,
   parameter int unsigned NSEL   = 4,
   parameter int unsigned IDX_W  = 2,
   parameter logic [ADDR_W-1:0] OFF_REMAP = 'h00,
   parameter logic [ADDR_W-1:0] OFF_MODE  = 'h04,
   parameter logic [ADDR_W-1:0] OFF_SEL0  = 'h08,
   parameter logic [ADDR_W-1:0] OFF_COMP  = 'h20
) (
   input  logic [ADDR_W-1:0] addr,
   output reg_kind_e         kind,
   output logic [IDX_W-1:0]  idx
);
   always_comb begin
      kind = RK_NONE;
      idx  = '0;
      if (addr[1:0] == 2'b00) begin
         if (addr == OFF_REMAP)     kind = RK_REMAP;
         else if (addr == OFF_MODE) kind = RK_MODE;
         else if (addr == OFF_COMP) kind = RK_COMP;
         for (int j = 0; j < NSEL; j++) begin
            if (addr == OFF_SEL0 + ADDR_W'(4 * j)) begin
               kind = RK_SEL;
               idx  = IDX_W'(j);
            end
         end
      end
   end
endmodule

// File: rtl/irq_router_regs.sv
module irq_router_regs
   import irq_router_pkg::*;
#(
   parameter int unsigned ADDR_W     = 10,
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned NSEL       = 4,
   parameter int unsigned FIELD_BITS = 16,
   parameter int unsigned IDX_W      = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       bus_en,
   input  logic                       bus_wr,
   input  logic [ADDR_W-1:0]          bus_addr,
   input  logic [DATA_W-1:0]          bus_wdata,
   output logic [DATA_W-1:0]          bus_rdata,
   output logic                       err_o,
   output logic [NSEL*FIELD_BITS-1:0] sel_flat
);
   reg_kind_e              kind;
   logic [IDX_W-1:0]       idx;
   logic [FIELD_BITS-1:0]  sel_q [NSEL];
   logic [DATA_W-1:0]      comp_q;
   logic [DATA_W-1:0]      rd_mux;

   irq_router_dec #(.ADDR_W(ADDR_W), .NSEL(NSEL), .IDX_W(IDX_W)) u_dec (
      .addr (bus_addr),
      .kind (kind),
      .idx  (idx)
   );

   always_comb begin
      case (kind)
         RK_SEL:  rd_mux = DATA_W'(sel_q[idx]);
         RK_COMP: rd_mux = comp_q;
         default: rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int j = 0; j < NSEL; j++) sel_q[j] <= '0;
         comp_q    <= '0;
         bus_rdata <= '0;
         err_o     <= 1'b0;
      end else begin
         err_o <= bus_en && (kind == RK_NONE);
         if (bus_en && bus_wr) begin
            case (kind)
               RK_SEL:  sel_q[idx] <= bus_wdata[FIELD_BITS-1:0];
               RK_COMP: comp_q     <= bus_wdata;
               default: ;
            endcase
         end
         if (bus_en && !bus_wr) bus_rdata <= rd_mux;
      end
   end

   for (genvar j = 0; j < NSEL; j++) begin : g_flat
      assign sel_flat[j*FIELD_BITS +: FIELD_BITS] = sel_q[j];
   end
endmodule

// File: rtl/irq_router_mux.sv
module irq_router_mux #(
   parameter int unsigned PORTS = 9,
   parameter int unsigned PINS  = 16,
   parameter int unsigned SEL_W = 4
) (
   input  logic [PINS*SEL_W-1:0]  sel_flat,
   input  logic [PORTS*PINS-1:0]  pin_i,
   output logic [PINS-1:0]        line_o
);
   for (genvar k = 0; k < PINS; k++) begin : g_line
      logic [SEL_W-1:0] s;
      logic             lvl;
      assign s = sel_flat[k*SEL_W +: SEL_W];
      if ((2 ** SEL_W) > PORTS) begin : g_guarded
         always_comb begin
            lvl = 1'b0;
            for (int p = 0; p < PORTS; p++)
               if (s == SEL_W'(p)) lvl = pin_i[p*PINS + k];
         end
      end else begin : g_full
         always_comb begin
            lvl = 1'b0;
            for (int p = 0; p < (2 ** SEL_W); p++)
               if (s == SEL_W'(p)) lvl = pin_i[p*PINS + k];
         end
      end
      assign line_o[k] = lvl;
   end
endmodule

// File: rtl/irq_line_router.sv
module irq_line_router #(
   parameter int unsigned PORTS  = 9,
   parameter int unsigned PINS   = 16,
   parameter int unsigned SEL_W  = 4,
   parameter int unsigned ADDR_W = 10,
   parameter int unsigned DATA_W = 32
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    bus_en,
   input  logic                    bus_wr,
   input  logic [ADDR_W-1:0]       bus_addr,
   input  logic [DATA_W-1:0]       bus_wdata,
   output logic [DATA_W-1:0]       bus_rdata,
   output logic                    err_o,
   input  logic [PORTS*PINS-1:0]   pin_i,
   output logic [PINS-1:0]         line_o
);
   localparam int unsigned PER_REG    = 4;
   localparam int unsigned NSEL       = PINS / PER_REG;
   localparam int unsigned FIELD_BITS = PER_REG * SEL_W;
   localparam int unsigned IDX_W      = (NSEL > 1) ? $clog2(NSEL) : 1;

   if (FIELD_BITS > DATA_W) begin : g_bad_width
      $error("select fields do not fit a data word");
   end
   if ((PINS % PER_REG) != 0) begin : g_bad_pins
      $error("pin count must be a multiple of fields per register");
   end
   if ((2 ** SEL_W) < PORTS) begin : g_bad_sel
      $error("select field too narrow for port count");
   end

   logic [PINS*SEL_W-1:0] sel_flat;

   irq_router_regs #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NSEL(NSEL),
      .FIELD_BITS(FIELD_BITS), .IDX_W(IDX_W)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_en    (bus_en),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .err_o     (err_o),
      .sel_flat  (sel_flat)
   );

   irq_router_mux #(.PORTS(PORTS), .PINS(PINS), .SEL_W(SEL_W)) u_mux (
      .sel_flat (sel_flat),
      .pin_i    (pin_i),
      .line_o   (line_o)
   );
endmodule

// File: rtl/irq_line_router_chk.sv
module irq_line_router_chk #(
   parameter int unsigned PORTS  = 9,
   parameter int unsigned PINS   = 16,
   parameter int unsigned ADDR_W = 10,
   parameter int unsigned DATA_W = 32
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  bus_en,
   input logic                  bus_wr,
   input logic [ADDR_W-1:0]     bus_addr,
   input logic [DATA_W-1:0]     bus_rdata,
   input logic                  err_o,
   input logic [PORTS*PINS-1:0] pin_i,
   input logic [PINS-1:0]       line_o
);
   logic mapped, legacy, selreg, armed;

   always_comb begin
      legacy = (bus_addr == ADDR_W'('h00)) || (bus_addr == ADDR_W'('h04));
      selreg = (bus_addr[1:0] == 2'b00) && (bus_addr >= ADDR_W'('h08))
               && (bus_addr <= ADDR_W'('h14));
      mapped = legacy || selreg || (bus_addr == ADDR_W'('h20));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) armed <= 1'b0;
      else        armed <= 1'b1;
   end

   // R8: flag follows an unmapped access by exactly one cycle
   a_r8_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      armed |-> (err_o == $past(bus_en && !mapped)));

   // R7: unmapped read returns zero
   a_r7_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_en && !bus_wr && !mapped) |=> (bus_rdata == '0));

   // R4: legacy words always read zero
   a_r4_legacy_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_en && !bus_wr && legacy) |=> (bus_rdata == '0));

   // R3: select registers never show upper half bits
   a_r3_upper_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_en && !bus_wr && selreg) |=> (bus_rdata[DATA_W-1:16] == '0));

   // R9: read data holds when no read is issued
   a_r9_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && !(bus_en && !bus_wr)) |=> $stable(bus_rdata));

   // R1: a line cannot be high while every pin is low
   a_r1_no_phantom: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_i == '0) |-> (line_o == '0));
endmodule

bind irq_line_router irq_line_router_chk #(
   .PORTS(PORTS), .PINS(PINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_wr(bus_wr),
   .bus_addr(bus_addr), .bus_rdata(bus_rdata), .err_o(err_o),
   .pin_i(pin_i), .line_o(line_o)
);

// File: tb/irq_line_router_bench.sv
module irq_line_router_bench;
   logic          clk = 1'b0;
   logic          rst_n;
   logic          bus_en, bus_wr;
   logic [9:0]    bus_addr;
   logic [31:0]   bus_wdata;
   logic [31:0]   bus_rdata;
   logic          err_o;
   logic [143:0]  pin_i;
   logic [15:0]   line_o;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   always #5 clk = ~clk;

   irq_line_router u_irq_line_router (
      .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .err_o(err_o), .pin_i(pin_i), .line_o(line_o)
   );

   // {offset, write data, expected read, expected error}
   localparam logic [74:0] VEC [0:10] = '{
      {10'h008, 32'hFFFF_1234, 32'h0000_1234, 1'b0},
      {10'h00C, 32'h0000_5678, 32'h0000_5678, 1'b0},
      {10'h010, 32'h1234_9ABC, 32'h0000_9ABC, 1'b0},
      {10'h014, 32'hFFFF_FFFF, 32'h0000_FFFF, 1'b0},
      {10'h020, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 1'b0},
      {10'h000, 32'hFFFF_FFFF, 32'h0000_0000, 1'b0},
      {10'h004, 32'h1234_5678, 32'h0000_0000, 1'b0},
      {10'h018, 32'hFFFF_FFFF, 32'h0000_0000, 1'b1},
      {10'h01C, 32'h5555_5555, 32'h0000_0000, 1'b1},
      {10'h3FC, 32'hAAAA_AAAA, 32'h0000_0000, 1'b1},
      {10'h009, 32'h0000_1111, 32'h0000_0000, 1'b1}
   };

   logic [3:0] cfg [16];

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [9:0] a, input logic [31:0] d, output logic e);
      @(negedge clk);
      bus_en = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_en = 0; bus_wr = 0;
      e = err_o;
   endtask

   task automatic bus_read(input logic [9:0] a, output logic [31:0] d, output logic e);
      @(negedge clk);
      bus_en = 1; bus_wr = 0; bus_addr = a;
      @(negedge clk);
      bus_en = 0;
      d = bus_rdata; e = err_o;
   endtask

   task automatic apply_cfg();
      logic e;
      for (int j = 0; j < 4; j++)
         bus_write(10'h008 + 10'(4*j),
                   {16'h0, cfg[4*j+3], cfg[4*j+2], cfg[4*j+1], cfg[4*j]}, e);
   endtask

   function automatic logic [15:0] model_lines(input logic [143:0] p);
      logic [15:0] r;
      for (int k = 0; k < 16; k++)
         r[k] = (cfg[k] < 9) ? p[cfg[k]*16 + k] : 1'b0;
      return r;
   endfunction

   task automatic check_lines(input string req, input logic [143:0] p);
      @(negedge clk);
      pin_i = p;
      #1;
      check(req, {16'h0, line_o}, {16'h0, model_lines(p)});
   endtask

   function automatic logic [143:0] hash_pins(input int seed);
      logic [143:0] r;
      for (int i = 0; i < 144; i++) r[i] = (((i * 7 + seed * 13) % 5) < 2);
      return r;
   endfunction

   initial begin
      logic [31:0] rd;
      logic        e, e2;
      bus_en = 0; bus_wr = 0; bus_addr = '0; bus_wdata = '0; pin_i = '0;
      rst_n = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;

      // R6: reset values and port 0 routing
      check("R8 err after reset", {31'h0, err_o}, 32'h0);
      for (int j = 0; j < 8; j++) begin
         bus_read(10'(4*j) + ((j > 5) ? 10'h8 : 10'h0), rd, e);
         check("R6 reset value", rd, 32'h0);
      end
      for (int k = 0; k < 16; k++) cfg[k] = 4'd0;
      check_lines("R6 port0 after reset", hash_pins(3));
      check_lines("R6 port0 after reset", {128'h0, 16'hA5C3});

      // R3 R4 R5 R7 R8: register table
      foreach (VEC[i]) begin
         bus_write(VEC[i][74:65], VEC[i][64:33], e);
         bus_read(VEC[i][74:65], rd, e2);
         check("R3/R4/R5/R7 readback", rd, VEC[i][32:1]);
         check("R8 err on write", {31'h0, e}, {31'h0, VEC[i][0]});
         check("R8 err on read", {31'h0, e2}, {31'h0, VEC[i][0]});
      end

      // R7: stray writes left select and comp words intact
      bus_read(10'h008, rd, e);
      check("R7 sel0 untouched", rd, 32'h0000_1234);
      bus_read(10'h020, rd, e);
      check("R7 comp untouched", rd, 32'hDEAD_BEEF);

      // R8: single-cycle pulse
      bus_write(10'h018, 32'h1, e);
      check("R8 pulse high", {31'h0, e}, 32'h1);
      @(negedge clk);
      check("R8 pulse cleared", {31'h0, err_o}, 32'h0);

      // R9: read data holds across a write
      bus_read(10'h020, rd, e);
      bus_write(10'h00C, 32'h0, e);
      check("R9 rdata hold", bus_rdata, 32'hDEAD_BEEF);

      // R1: each line picks a different port
      for (int k = 0; k < 16; k++) cfg[k] = 4'(k % 9);
      apply_cfg();
      for (int p = 0; p < 9; p++)
         check_lines("R1 walking port", {128'h0, 16'hFFFF} << (p * 16));
      check_lines("R1 hash pattern", hash_pins(1));
      check_lines("R1 hash pattern", hash_pins(2));
      check_lines("R1 all ones", {144{1'b1}});

      // R2: out-of-range fields drive low
      for (int k = 0; k < 16; k++) cfg[k] = 4'(15 - k);
      apply_cfg();
      check_lines("R2 all ones", {144{1'b1}});
      check_lines("R2 hash pattern", hash_pins(4));
      @(negedge clk);
      pin_i = {144{1'b1}};
      #1;
      check("R2 lines 0..6 low", {25'h0, line_o[6:0]}, 32'h0);

      // R3: field position inside a register
      for (int k = 0; k < 16; k++) cfg[k] = 4'd0;
      cfg[6] = 4'd8;
      apply_cfg();
      check_lines("R3 field of line 6", {16'h0040, 128'h0});
      check_lines("R3 field of line 6", {16'hFFBF, 112'h0, 16'h0040});

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule